// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block produces the active-low read and write strobes that a disk controller presents to an IDE drive during programmed-I/O register and data transfers. The host-side address decoder issues a one-clock start request together with a direction bit. The block then drives the matching strobe low for a programmed number of host clocks, which is the active phase. It raises the strobe and keeps both strobes high for a programmed recovery phase. When the active phase ends, it tells the host that the access is complete with a one-clock low pulse on a local-ready output.

Two timing values set the phase lengths. At reset they come from two strap pins. After reset, software can replace them with a timing byte that holds a 4-bit code for each phase. The drive's ready line reaches the block through a synchronizer and can hold the active phase open for as long as the drive needs. A request that arrives while an access is still running is kept in a one-entry slot. It is launched as soon as the recovery phase ends.

Top module: `pio_strobe_gen`

## Requirements
- R1: While `rst_n` is low, `rd_strobe_n`, `wr_strobe_n` and `host_done_n` are all high.
- R2: The value {`strap_pri`,`strap_sec`} present in the clocks before `rst_n` rises sets both the active count and the recovery count: 2'b00 gives 15 cycles, 2'b01 gives 10, 2'b10 gives 7 and 2'b11 gives 4.
- R3: A clock with `cfg_we` high after reset loads `cfg_byte`. Bits 7:4 are the recovery code and bits 3:0 are the active code. A code n in the range 2..15 gives n cycles. The new values apply from the next phase that starts.
- R4: A code of 0 gives 16 cycles, and a code of 1 gives 2 cycles.
- R5: A request with `xfer_wr`=0 lowers only `rd_strobe_n`, and a request with `xfer_wr`=1 lowers only `wr_strobe_n`. The two strobes are never low in the same cycle.
- R6: When `drv_rdy` is high, the strobe of a request sampled at clock edge k is low for exactly the active count of cycles, starting right after edge k.
- R7: `drv_rdy` passes through two flops before use. While the synchronized ready is low at the end of the active count, the strobe stays low. If `drv_rdy` rises after the count has expired, the strobe rises on the third rising clock edge after that.
- R8: `host_done_n` is low for exactly one clock. That clock is the first one after the strobe rises.
- R9: Both strobes stay high for the full recovery count after an active phase. A request accepted during the active or recovery phase is held, with its own direction, and its strobe falls in the cycle right after recovery ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low reset; straps are captured while low |
| strap_pri | input | 1 | Upper strap bit for default timing |
| strap_sec | input | 1 | Lower strap bit for default timing |
| cfg_we | input | 1 | Load strobe for the software timing byte |
| cfg_byte | input | 8 | Timing byte: recovery code [7:4], active code [3:0] |
| xfer_req | input | 1 | One-clock start request from the host decoder |
| xfer_wr | input | 1 | Direction of the request: 1 write, 0 read |
| drv_rdy | input | 1 | Drive ready, asynchronous; low stretches the active phase |
| rd_strobe_n | output | 1 | Active-low drive read strobe |
| wr_strobe_n | output | 1 | Active-low drive write strobe |
| host_done_n | output | 1 | Active-low one-clock completion pulse to the host |

## Verification
A down-counter that is loaded with the wrong value shows at once as a strobe that is low for the wrong number of clocks. The bench therefore counts low samples of each strobe per access and compares them with the decoded strap or code. A fault in the phase or direction register appears within one access: the wrong strobe falls, both strobes fall together, or the completion pulse is missing or lasts longer than one clock. A fault in the pending slot or the recovery counter only shows on back-to-back requests. It appears as a high gap between strobes that is not equal to the recovery count, or as a held request that comes out with the wrong direction.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;

  localparam int FIELD_W = 4;
  localparam int CNT_W   = FIELD_W + 1;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACT  = 2'd1,
    PH_REC  = 2'd2
  } phase_t;

  // 4-bit code to cycle count: 0 -> 16, 1 -> 2, otherwise n.
  function automatic logic [CNT_W-1:0] code_to_cycles(input logic [FIELD_W-1:0] code);
    logic [CNT_W-1:0] r;
    if (code == '0)
      r = CNT_W'(1 << FIELD_W);
    else if (code == FIELD_W'(1))
      r = CNT_W'(2);
    else
      r = CNT_W'(code);
    return r;
  endfunction

  // Strap pair {upper, lower} to cycle count shared by both phases.
  function automatic logic [CNT_W-1:0] strap_to_cycles(input logic [1:0] strap);
    logic [CNT_W-1:0] r;
    unique case (strap)
      2'b00:   r = CNT_W'(15);
      2'b01:   r = CNT_W'(10);
      2'b10:   r = CNT_W'(7);
      default: r = CNT_W'(4);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pio_rdy_sync.sv
module pio_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];

  // R7: output follows the previous stage one clock later
  a_r7_sync_shift: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sync_out == $past(chain_q[STAGES-2])));
endmodule

// File: rtl/pio_timing_cfg.sv
module pio_timing_cfg
  import pio_timing_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_hi,
  input  logic             strap_lo,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_byte,
  output logic [CNT_W-1:0] act_cycles,
  output logic [CNT_W-1:0] rec_cycles
);
  logic [CNT_W-1:0] act_q, rec_q;
  logic [CNT_W-1:0] strap_cyc;

  assign strap_cyc = strap_to_cycles({strap_hi, strap_lo});

  // Straps are reloaded on every clock while reset is low, so the last
  // value before reset rises stays in the register.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= strap_cyc;
      rec_q <= strap_cyc;
    end else if (cfg_we) begin
      act_q <= code_to_cycles(cfg_byte[FIELD_W-1:0]);
      rec_q <= code_to_cycles(cfg_byte[2*FIELD_W-1:FIELD_W]);
    end
  end

  assign act_cycles = act_q;
  assign rec_cycles = rec_q;

  // R4: decoded counts always lie in 2..16
  a_r4_act_range: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cycles >= CNT_W'(2)) && (act_cycles <= CNT_W'(16)));
  a_r4_rec_range: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_cycles >= CNT_W'(2)) && (rec_cycles <= CNT_W'(16)));
  // R3: without a write the timing holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(act_cycles) && $stable(rec_cycles));
endmodule

// File: rtl/pio_strobe_fsm.sv
module pio_strobe_fsm
  import pio_timing_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_wr,
  input  logic             rdy_s,
  input  logic [CNT_W-1:0] act_cycles,
  input  logic [CNT_W-1:0] rec_cycles,
  output logic             rd_n,
  output logic             wr_n,
  output logic             done_n
);
  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             dir_wr_q;
  logic             pend_q, pend_wr_q;
  logic             done_q;

  // Named internal events
  logic cnt_zero, act_done, act_wait, rec_done, can_launch, launch, launch_wr;

  assign cnt_zero   = (cnt_q == '0);
  assign act_done   = (phase_q == PH_ACT) && cnt_zero && rdy_s;
  assign act_wait   = (phase_q == PH_ACT) && cnt_zero && !rdy_s;
  assign rec_done   = (phase_q == PH_REC) && cnt_zero;
  assign can_launch = (phase_q == PH_IDLE) || rec_done;
  assign launch     = can_launch && (pend_q || req);
  assign launch_wr  = pend_q ? pend_wr_q : req_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      dir_wr_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= act_done;
      if (launch) begin
        phase_q  <= PH_ACT;
        cnt_q    <= act_cycles - CNT_W'(1);
        dir_wr_q <= launch_wr;
      end else if (act_done) begin
        phase_q <= PH_REC;
        cnt_q   <= rec_cycles - CNT_W'(1);
      end else if (rec_done) begin
        phase_q <= PH_IDLE;
      end else if (!cnt_zero) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  // One-entry slot for a request that arrives while an access runs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      pend_wr_q <= 1'b0;
    end else if (launch && pend_q) begin
      pend_q    <= req;
      pend_wr_q <= req_wr;
    end else if (req && !pend_q && !launch) begin
      pend_q    <= 1'b1;
      pend_wr_q <= req_wr;
    end
  end

  assign rd_n   = !((phase_q == PH_ACT) && !dir_wr_q);
  assign wr_n   = !((phase_q == PH_ACT) &&  dir_wr_q);
  assign done_n = !done_q;

  // R5: never both strobes low
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n || wr_n);
  // R6: active phase continues while count is running
  a_r6_min_active: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_ACT) && !cnt_zero) |=> (phase_q == PH_ACT));
  // R7: not-ready holds the active phase
  a_r7_hold_notready: assert property (@(posedge clk) disable iff (!rst_n)
    act_wait |=> (phase_q == PH_ACT) && $stable(dir_wr_q));
  // R8: completion pulse lasts one clock
  a_r8_done_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_n |=> done_n);
  // R8: completion pulse follows a strobe that just rose
  a_r8_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_n) |-> rd_n && wr_n && !($past(rd_n) && $past(wr_n)));
  // R9: recovery keeps going until its count expires
  a_r9_rec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_REC) && !cnt_zero) |=> (phase_q == PH_REC));
  // R9: a held request launches right after recovery
  a_r9_pend_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_done && pend_q) |=> (phase_q == PH_ACT) && (dir_wr_q == $past(pend_wr_q)));
endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
  import pio_timing_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_pri,
  input  logic       strap_sec,
  input  logic       cfg_we,
  input  logic [7:0] cfg_byte,
  input  logic       xfer_req,
  input  logic       xfer_wr,
  input  logic       drv_rdy,
  output logic       rd_strobe_n,
  output logic       wr_strobe_n,
  output logic       host_done_n
);
  logic             rdy_sync;
  logic [CNT_W-1:0] act_cycles, rec_cycles;

  pio_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (drv_rdy),
    .sync_out (rdy_sync)
  );

  pio_timing_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_hi   (strap_pri),
    .strap_lo   (strap_sec),
    .cfg_we     (cfg_we),
    .cfg_byte   (cfg_byte),
    .act_cycles (act_cycles),
    .rec_cycles (rec_cycles)
  );

  pio_strobe_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (xfer_req),
    .req_wr     (xfer_wr),
    .rdy_s      (rdy_sync),
    .act_cycles (act_cycles),
    .rec_cycles (rec_cycles),
    .rd_n       (rd_strobe_n),
    .wr_n       (wr_strobe_n),
    .done_n     (host_done_n)
  );

  // R1: reset holds all three outputs high
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_high: assert (rd_strobe_n && wr_strobe_n && host_done_n);
    end
  end
endmodule

// File: tb/pio_strobe_gen_tb_top.sv
module pio_strobe_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap_pri = 1'b1, strap_sec = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_byte = 8'h00;
  logic       xfer_req = 1'b0, xfer_wr = 1'b0;
  logic       drv_rdy = 1'b1;
  logic       rd_strobe_n, wr_strobe_n, host_done_n;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  pio_strobe_gen dut_i (
    .clk(clk), .rst_n(rst_n), .strap_pri(strap_pri), .strap_sec(strap_sec),
    .cfg_we(cfg_we), .cfg_byte(cfg_byte), .xfer_req(xfer_req), .xfer_wr(xfer_wr),
    .drv_rdy(drv_rdy), .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n),
    .host_done_n(host_done_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int code_cycles(input int c);
    if (c == 0) return 16;
    if (c == 1) return 2;
    return c;
  endfunction

  function automatic logic sel_strobe(input logic w);
    return w ? wr_strobe_n : rd_strobe_n;
  endfunction

  task automatic do_reset(input logic p, input logic s);
    rst_n = 1'b0; strap_pri = p; strap_sec = s;
    repeat (4) @(negedge clk);
    chk(rd_strobe_n && wr_strobe_n && host_done_n, "R1 reset outputs high",
        {rd_strobe_n, wr_strobe_n, host_done_n}, 7);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [7:0] b);
    @(negedge clk); cfg_we = 1'b1; cfg_byte = b;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // Pulse a request; returns at the first sample after it was taken.
  task automatic pulse_req(input logic w);
    @(negedge clk); xfer_req = 1'b1; xfer_wr = w;
    @(negedge clk); xfer_req = 1'b0;
  endtask

  // Counts low samples of strobe w from the current sample on, optionally
  // queues a second request on the first sample. Checks R5 and R8.
  task automatic measure(input logic w, input bit queue, input logic w2,
                         input string tag, output int n);
    int guard;
    bit other_ok;
    n = 0; guard = 0; other_ok = 1'b1;
    while (sel_strobe(w) == 1'b0 && guard < 100) begin
      if (sel_strobe(!w) == 1'b0) other_ok = 1'b0;
      n++; guard++;
      if (queue && n == 1) begin xfer_req = 1'b1; xfer_wr = w2; end
      @(negedge clk);
      if (queue && n == 1) xfer_req = 1'b0;
    end
    chk(guard < 100, {tag, " watchdog"}, guard, 0);
    chk(other_ok, {"R5 other strobe high ", tag}, other_ok, 1);
    chk(host_done_n == 1'b0, {"R8 done low after strobe ", tag}, host_done_n, 0);
    @(negedge clk);
    chk(host_done_n == 1'b1, {"R8 done one clock ", tag}, host_done_n, 1);
  endtask

  // After measure(): count high gap (done sample counted already) until next strobe.
  task automatic gap_to_next(input logic w2, input string tag, output int g);
    g = 2;
    while (rd_strobe_n && wr_strobe_n && g < 100) begin
      g++;
      @(negedge clk);
    end
    g--;
    chk(sel_strobe(w2) == 1'b0, {"R9 held direction ", tag}, sel_strobe(w2), 0);
  endtask

  task automatic t_reset_straps();
    int n, g;
    int exp_tab [4] = '{15, 10, 7, 4};
    for (int s = 0; s < 4; s++) begin
      do_reset(s[1], s[0]);
      pulse_req(1'b0);
      measure(1'b0, 1'b1, 1'b1, "R2 strap", n);
      chk(n == exp_tab[s], "R2 R6 strap active count", n, exp_tab[s]);
      gap_to_next(1'b1, "R2 strap", g);
      chk(g == exp_tab[s], "R2 R9 strap recovery count", g, exp_tab[s]);
      measure(1'b1, 1'b0, 1'b0, "R9 second", n);
      chk(n == exp_tab[s], "R9 held write active count", n, exp_tab[s]);
      repeat (20) @(negedge clk);
    end
  endtask

  task automatic t_soft_byte(input logic [7:0] b, input string tag);
    int n, g, ea, er;
    ea = code_cycles(int'(b[3:0]));
    er = code_cycles(int'(b[7:4]));
    write_cfg(b);
    pulse_req(1'b1);
    measure(1'b1, 1'b1, 1'b0, tag, n);
    chk(n == ea, {tag, " active count"}, n, ea);
    gap_to_next(1'b0, tag, g);
    chk(g == er, {tag, " recovery count"}, g, er);
    measure(1'b0, 1'b0, 1'b0, tag, n);
    chk(n == ea, {tag, " held read active"}, n, ea);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_stretch();
    int n, guard;
    write_cfg(8'h44);
    drv_rdy = 1'b0;
    repeat (4) @(negedge clk);
    pulse_req(1'b0);
    n = 0; guard = 0;
    while (rd_strobe_n == 1'b0 && guard < 100) begin
      n++; guard++;
      if (n == 6) drv_rdy = 1'b1;
      @(negedge clk);
    end
    chk(n == 8, "R7 ready stretch length", n, 8);
    chk(host_done_n == 1'b0, "R7 R8 done after stretch", host_done_n, 0);
    repeat (20) @(negedge clk);
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    n_errors++; n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    t_reset_straps();
    t_soft_byte(8'h96, "R3 code 6/9");
    t_soft_byte(8'h01, "R4 code 1 active 0 recovery");
    t_soft_byte(8'h10, "R4 code 0 active 1 recovery");
    t_stretch();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule